// File: doc/BRIEF.md
# Lane-Aware PHY Power-Up Sequencer

This block powers up the analog front end of a serial display PHY with up to four data lanes. A power-on request starts a fixed series of steps, one step per group of enable outputs. The steps are the bias current, then three regulators, then clock-lane and data-lane termination, then the divider, then the clock path, then the termination mode, and last the per-lane serializers. A timed wait, counted in clock cycles, separates each step from the next. The first wait is longer than the others, because the bias has to settle before anything else is switched on.

The lane count comes in on a small input and is captured when a power-on request is accepted. From it the block forms a thermometer lane mask. That mask gates the per-lane termination enables and the per-lane serializer enables. A power-off request withdraws only the termination mode and leaves every other enable as it is. `busy` is high while the series is running. `ready` is high once it has finished.

Top module: `phy_pwrup_seq`

## Requirements
- R1: Reset drives every enable output, `busy`, `ready` and `laneField` to 0.
- R2: The effective lane count is the `laneCount` input, except that 0 counts as 1 and any value above LANES counts as LANES. Bit i of the lane mask is 1 exactly when i is below the effective count. `laneField` shows (effective count − 1) from the clock edge that accepts the request.
- R3: A power-on request is accepted at a clock edge where `busy` is low. That same edge sets `biasEn` and `busy` and clears `ready`.
- R4: All three bits of `regEn` rise together, LONG_WAIT cycles after `biasEn` rises.
- R5: `clkTermEn` rises SHORT_WAIT cycles after `regEn`. At the same edge `dataTermEn` takes the lane mask.
- R6: `divEn` rises SHORT_WAIT cycles after the termination step.
- R7: `clkPathEn` rises SHORT_WAIT cycles after `divEn`.
- R8: `termModeEn` rises SHORT_WAIT cycles after `clkPathEn`. One cycle later, `serEn` takes the lane mask, `ready` rises and `busy` falls.
- R9: A power-off request sampled at an edge clears `termModeEn` and changes no other output. It wins over the step that would set `termModeEn` at that same edge.
- R10: A power-on request made while `busy` is high is ignored. This includes the `laneCount` value presented with it.
- R11: `laneField` and the lane mask do not change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrOnReq | input | 1 | Request to start the power-up series |
| pwrOffReq | input | 1 | Request to drop the termination mode |
| laneCount | input | $clog2(LANES+1) | Number of active lanes |
| laneField | output | $clog2(LANES) | Captured lane count minus one |
| biasEn | output | 1 | Bias current enable |
| regEn | output | 3 | Regulator enables |
| clkTermEn | output | 1 | Clock-lane termination enable |
| dataTermEn | output | LANES | Per-lane data termination enables |
| divEn | output | 1 | Divider enable |
| clkPathEn | output | 1 | Clock path enable |
| termModeEn | output | 1 | Termination mode |
| serEn | output | LANES | Per-lane serializer enables |
| busy | output | 1 | Series in progress |
| ready | output | 1 | Series complete |

## Verification
A power-off request and the step that sets the termination mode can land on the same clock edge, and in that case the power-off must win. The bench provokes this by holding `pwrOffReq` high for exactly that edge. It expects `termModeEn` to stay low while the serializer step, `ready` and the rest of the enables arrive on schedule. It also fires power-off before that edge and after `ready`, and checks the full output vector against the arithmetic schedule every cycle.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIAS,
    ST_REG,
    ST_TERM,
    ST_DIV,
    ST_CLK,
    ST_SER,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic start;
    logic stepReg;
    logic stepTerm;
    logic stepDiv;
    logic stepClk;
    logic stepMode;
    logic stepSer;
    logic clrMode;
  } seqStrobe_t;

endpackage

// File: rtl/phy_pwrup_ctrl.sv
module phy_pwrup_ctrl
  import phy_pwrup_pkg::*;
#(
  parameter int LONG_WAIT  = 750,
  parameter int SHORT_WAIT = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOnReq,
  input  logic       pwrOffReq,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       ready
);

  localparam int MAX_WAIT = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_WAIT - 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_WAIT - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             waitDone;

  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign ready    = (state == ST_DONE);
  assign waitDone = (waitCnt == '0);

  always_comb begin
    strobe         = '0;
    strobe.clrMode = pwrOffReq;
    stateNext      = state;
    waitCntNext    = waitDone ? waitCnt : waitCnt - 1'b1;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (pwrOnReq) begin
          strobe.start = 1'b1;
          stateNext    = ST_BIAS;
          waitCntNext  = LONG_LOAD;
        end
      end
      ST_BIAS: if (waitDone) begin
        strobe.stepReg = 1'b1;
        stateNext      = ST_REG;
        waitCntNext    = SHORT_LOAD;
      end
      ST_REG: if (waitDone) begin
        strobe.stepTerm = 1'b1;
        stateNext       = ST_TERM;
        waitCntNext     = SHORT_LOAD;
      end
      ST_TERM: if (waitDone) begin
        strobe.stepDiv = 1'b1;
        stateNext      = ST_DIV;
        waitCntNext    = SHORT_LOAD;
      end
      ST_DIV: if (waitDone) begin
        strobe.stepClk = 1'b1;
        stateNext      = ST_CLK;
        waitCntNext    = SHORT_LOAD;
      end
      ST_CLK: if (waitDone) begin
        strobe.stepMode = 1'b1;
        stateNext       = ST_SER;
      end
      ST_SER: begin
        strobe.stepSer = 1'b1;
        stateNext      = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

endmodule

// File: rtl/phy_pwrup_dpath.sv
module phy_pwrup_dpath
  import phy_pwrup_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES + 1),
  localparam int FW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CW-1:0]    laneCount,
  output logic [FW-1:0]    laneField,
  output logic             biasEn,
  output logic [2:0]       regEn,
  output logic             clkTermEn,
  output logic [LANES-1:0] dataTermEn,
  output logic             divEn,
  output logic             clkPathEn,
  output logic             termModeEn,
  output logic [LANES-1:0] serEn
);

  logic [CW-1:0]    effLanes;
  logic [LANES-1:0] maskNew;
  logic [LANES-1:0] laneMask;

  always_comb begin
    effLanes = laneCount;
    if (laneCount == '0) effLanes = CW'(1);
    else if (int'(laneCount) > LANES) effLanes = CW'(LANES);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign maskNew[i] = (i < int'(effLanes));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneMask   <= '0;
      laneField  <= '0;
      biasEn     <= 1'b0;
      regEn      <= '0;
      clkTermEn  <= 1'b0;
      dataTermEn <= '0;
      divEn      <= 1'b0;
      clkPathEn  <= 1'b0;
      termModeEn <= 1'b0;
      serEn      <= '0;
    end else begin
      if (strobe.start) begin
        laneMask  <= maskNew;
        laneField <= FW'(effLanes - 1'b1);
        biasEn    <= 1'b1;
      end
      if (strobe.stepReg) regEn <= 3'b111;
      if (strobe.stepTerm) begin
        clkTermEn  <= 1'b1;
        dataTermEn <= laneMask;
      end
      if (strobe.stepDiv) divEn <= 1'b1;
      if (strobe.stepClk) clkPathEn <= 1'b1;
      if (strobe.clrMode) termModeEn <= 1'b0;
      else if (strobe.stepMode) termModeEn <= 1'b1;
      if (strobe.stepSer) serEn <= laneMask;
    end
  end

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_pwrup_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LONG_WAIT  = 750,
  parameter int SHORT_WAIT = 150,
  localparam int CW = $clog2(LANES + 1),
  localparam int FW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrOnReq,
  input  logic             pwrOffReq,
  input  logic [CW-1:0]    laneCount,
  output logic [FW-1:0]    laneField,
  output logic             biasEn,
  output logic [2:0]       regEn,
  output logic             clkTermEn,
  output logic [LANES-1:0] dataTermEn,
  output logic             divEn,
  output logic             clkPathEn,
  output logic             termModeEn,
  output logic [LANES-1:0] serEn,
  output logic             busy,
  output logic             ready
);

  seqStrobe_t strobe;

  phy_pwrup_ctrl #(
    .LONG_WAIT (LONG_WAIT),
    .SHORT_WAIT(SHORT_WAIT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pwrOnReq (pwrOnReq),
    .pwrOffReq(pwrOffReq),
    .strobe   (strobe),
    .busy     (busy),
    .ready    (ready)
  );

  phy_pwrup_dpath #(
    .LANES(LANES)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .laneCount (laneCount),
    .laneField (laneField),
    .biasEn    (biasEn),
    .regEn     (regEn),
    .clkTermEn (clkTermEn),
    .dataTermEn(dataTermEn),
    .divEn     (divEn),
    .clkPathEn (clkPathEn),
    .termModeEn(termModeEn),
    .serEn     (serEn)
  );

endmodule

// File: rtl/phy_pwrup_chk.sv
module phy_pwrup_chk #(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES + 1),
  localparam int FW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrOnReq,
  input logic             pwrOffReq,
  input logic [CW-1:0]    laneCount,
  input logic [FW-1:0]    laneField,
  input logic             biasEn,
  input logic [2:0]       regEn,
  input logic             clkTermEn,
  input logic [LANES-1:0] dataTermEn,
  input logic             divEn,
  input logic             clkPathEn,
  input logic             termModeEn,
  input logic [LANES-1:0] serEn,
  input logic             busy,
  input logic             ready
);

  // R8: busy and ready never overlap
  p_busy_ready_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && ready));

  // R4: regulators only come up behind the bias
  p_reg_after_bias_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regEn[0]) |-> biasEn && regEn == 3'b111);

  // R2: data termination mask is a thermometer code
  p_mask_thermo_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((dataTermEn + 1'b1) & dataTermEn) == '0);

  // R8: serializers follow the same mask as termination
  p_ser_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (serEn != '0) |-> (serEn == dataTermEn));

  // R9: power-off leaves termination mode low at the next edge
  p_off_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |=> !termModeEn);

  // R11: captured lane count is frozen while busy
  p_lane_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(laneField));

  // R7: clock path is never enabled ahead of the divider
  p_clk_after_div_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkPathEn |-> divEn);

endmodule

bind phy_pwrup_seq phy_pwrup_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/phy_pwrup_seq_tb_top.sv
module phy_pwrup_seq_tb_top;

  localparam int LANES = 4;
  localparam int L     = 20;
  localparam int S     = 5;
  localparam int CW    = $clog2(LANES + 1);
  localparam int FW    = $clog2(LANES);
  localparam int VW    = 1 + 3 + 1 + LANES + 1 + 1 + 1 + LANES + 1 + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pwrOnReq = 1'b0;
  logic             pwrOffReq = 1'b0;
  logic [CW-1:0]    laneCount = '0;
  logic [FW-1:0]    laneField;
  logic             biasEn, clkTermEn, divEn, clkPathEn, termModeEn, busy, ready;
  logic [2:0]       regEn;
  logic [LANES-1:0] dataTermEn, serEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phy_pwrup_seq #(.LANES(LANES), .LONG_WAIT(L), .SHORT_WAIT(S)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [VW-1:0] outVec();
    return {biasEn, regEn, clkTermEn, dataTermEn, divEn, clkPathEn, termModeEn, serEn, busy, ready};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pwrOnReq = 1'b0;
    pwrOffReq = 1'b0;
    @(negedge clk);
    chk(outVec() == '0 && laneField == '0, "R1 reset", 32'(outVec()), 0);
    rstN = 1'b1;
  endtask

  // offAt: edge index (0 = accepting edge) at which power-off is sampled, -1 none
  task automatic runSeq(input int lc, input int offAt);
    int eff = (lc == 0) ? 1 : ((lc > LANES) ? LANES : lc);
    logic [LANES-1:0] mask = LANES'((1 << eff) - 1);
    int modeAt = L + 4 * S;
    doReset();
    laneCount = CW'(lc);
    pwrOnReq  = 1'b1;
    pwrOffReq = (offAt == 0);
    for (int n = 0; n <= modeAt + 4; n++) begin
      logic [VW-1:0] exp;
      bit modeExp;
      string tag;
      @(negedge clk);
      modeExp = (n >= modeAt) && !(offAt >= modeAt && n >= offAt);
      exp = {1'b1,
             (n >= L) ? 3'b111 : 3'b000,
             n >= L + S,
             (n >= L + S) ? mask : '0,
             n >= L + 2 * S,
             n >= L + 3 * S,
             modeExp,
             (n >= modeAt + 1) ? mask : '0,
             n < modeAt + 1,
             n >= modeAt + 1};
      if (n < L) tag = "R3";
      else if (n < L + S) tag = "R4";
      else if (n < L + 2 * S) tag = "R5";
      else if (n < L + 3 * S) tag = "R6";
      else if (n < modeAt) tag = "R7";
      else if (offAt >= 0) tag = "R9";
      else tag = "R8";
      chk(outVec() == exp, tag, 32'(outVec()), 32'(exp));
      chk(laneField == FW'(eff - 1), (n > 4) ? "R10 R11" : "R2", 32'(laneField), 32'(eff - 1));
      pwrOnReq  = (n + 1 == 4);
      laneCount = (n + 1 == 4) ? CW'((lc + 2) % 5) : CW'(lc);
      pwrOffReq = (n + 1 == offAt);
    end
    pwrOnReq  = 1'b0;
    pwrOffReq = 1'b0;
  endtask

  initial begin
    for (int lc = 0; lc < (1 << CW); lc++) runSeq(lc, -1);
    runSeq(3, L + 4 * S);
    runSeq(2, L + 4 * S + 2);
    runSeq(4, 10);
    runSeq(1, L + S);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule